// File: doc/BRIEF.md
# Windowed Register File with Overlapping Procedure Windows

This block is a register file that gives each procedure its own set of registers without copying anything on a call. The physical storage holds a few global registers and a ring of procedure windows. A current-window pointer picks the active window, and every architectural register number from an instruction is translated to a physical register index through that pointer. Each window has three areas: incoming arguments, private locals and outgoing scratch registers. The scratch area of one window is the same storage as the argument area of the next window, so a caller passes values by writing its scratch registers and then calling.

A call strobe moves the current pointer forward one window and a return strobe moves it back. A saved-window pointer marks the boundary of the windows held on chip. If a call would run into that boundary, the block raises a spill request. If a return would cross it, the block raises a fill request. In both cases the pointer move waits until an external handler has moved the window's contents and pulses an acknowledge. The acknowledge moves the saved pointer one window and completes the delayed call or return. There are two combinational read ports and one clocked write port.

Top module: `regwin_file`

## Requirements
- R1: A synchronous active-high reset sets the current and saved window pointers to 0, clears any pending spill or fill request and clears every register, so all reads return 0.
- R2: When no trap is pending, a call with (current+1) mod N different from saved sets current to (current+1) mod N on the next clock edge. A return with (current-1) mod N different from saved sets current to (current-1) mod N.
- R3: When no trap is pending, a call with (current+1) mod N equal to saved raises spill_req_o after the edge, and current does not change. From reset this lets N-1 calls complete before the next call traps.
- R4: When no trap is pending, a return with (current-1) mod N equal to saved raises fill_req_o after the edge, and current does not change.
- R5: While a request is pending, call and return are ignored and both pointers hold. A trap_ack_i pulse clears the request on the next edge. For a spill it moves both pointers forward by one window; for a fill it moves both back by one.
- R6: If call and return are asserted together, the call acts and the return is ignored. A trap_ack_i with no pending request has no effect.
- R7: Architectural numbers 0 to 7 are global and map to the same storage for every window. Numbers 8 to 13 are the window's arguments, 14 to 17 its locals and 18 to 23 its scratch registers.
- R8: Scratch registers 18+k of window w are the same storage as argument registers 8+k of window (w+1) mod N, including the wrap from window N-1 to window 0.
- R9: Each window's locals are separate storage. Values written in one window are not visible as locals in another window, and they are kept while other windows are active.
- R10: Register 0 and the numbers 24 to 31 always read as 0. Writes to them are discarded and do not change any other register.
- R11: Reads are combinational and use the current window. A write commits on the clock edge, so a read of the same register in the write cycle returns the old value and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| trap_ack_i | input | 1 | Handler has finished the pending spill or fill |
| spill_req_o | output | 1 | Oldest window must be saved to memory |
| fill_req_o | output | 1 | Window must be restored from memory |
| cur_win_o | output | 3 | Current window pointer |
| saved_win_o | output | 3 | Saved window pointer |
| rd_addr_a_i | input | 5 | Architectural register for read port A |
| rd_data_a_o | output | 32 | Read port A data |
| rd_addr_b_i | input | 5 | Architectural register for read port B |
| rd_data_b_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Architectural register to write |
| wr_data_i | input | 32 | Write data |

## Verification
The bench builds the block with its default parameters: 8 windows, 8 global registers, 6 argument registers, 4 local registers and 6 scratch registers, each 32 bits wide. With eight windows, a short run of calls fills the ring, so the bench reaches the spill trap, the scratch-to-argument overlap across the wrap from window 7 to window 0, and then a fill trap after returns unwind past the saved window. Both traps are checked while their handler acknowledge is still outstanding, which shows that the pointers hold and that call strobes are ignored.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_SPILL = 2'd1,
        TRAP_FILL  = 2'd2
    } trap_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic ack;
    } win_cmd_t;

    function automatic int ring_next(int p, int n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

    function automatic int ring_prev(int p, int n);
        return (p == 0) ? n - 1 : p - 1;
    endfunction

endpackage

// File: rtl/regwin_ptr_ctrl.sv
module regwin_ptr_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  win_cmd_t      cmd,
    output logic [PW-1:0] cwp,
    output logic [PW-1:0] swp,
    output trap_e         trap
);

    logic [PW-1:0] cwp_q, swp_q, cwp_d, swp_d;
    logic [PW-1:0] cwp_fwd, cwp_bwd, swp_fwd, swp_bwd;
    trap_e         trap_q, trap_d;

    assign cwp_fwd = PW'(ring_next(int'(cwp_q), NWIN));
    assign cwp_bwd = PW'(ring_prev(int'(cwp_q), NWIN));
    assign swp_fwd = PW'(ring_next(int'(swp_q), NWIN));
    assign swp_bwd = PW'(ring_prev(int'(swp_q), NWIN));

    always_comb begin
        cwp_d  = cwp_q;
        swp_d  = swp_q;
        trap_d = trap_q;
        unique case (trap_q)
            TRAP_NONE: begin
                if (cmd.call) begin
                    if (cwp_fwd == swp_q) trap_d = TRAP_SPILL;
                    else                  cwp_d  = cwp_fwd;
                end else if (cmd.ret) begin
                    if (cwp_bwd == swp_q) trap_d = TRAP_FILL;
                    else                  cwp_d  = cwp_bwd;
                end
            end
            TRAP_SPILL: begin
                if (cmd.ack) begin
                    swp_d  = swp_fwd;
                    cwp_d  = cwp_fwd;
                    trap_d = TRAP_NONE;
                end
            end
            TRAP_FILL: begin
                if (cmd.ack) begin
                    swp_d  = swp_bwd;
                    cwp_d  = cwp_bwd;
                    trap_d = TRAP_NONE;
                end
            end
            default: trap_d = TRAP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q  <= '0;
            swp_q  <= '0;
            trap_q <= TRAP_NONE;
        end else begin
            cwp_q  <= cwp_d;
            swp_q  <= swp_d;
            trap_q <= trap_d;
        end
    end

    assign cwp  = cwp_q;
    assign swp  = swp_q;
    assign trap = trap_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cwp_q == '0 && swp_q == '0 && trap_q == TRAP_NONE));

    assert_call_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_q == TRAP_NONE && cmd.call && cwp_fwd != swp_q)
            |=> (int'(cwp_q) == ring_next(int'($past(cwp_q)), NWIN)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_q == TRAP_NONE && cmd.call && cwp_fwd == swp_q)
            |=> (trap_q == TRAP_SPILL && $stable(cwp_q)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (trap_q == TRAP_NONE && !cmd.call && cmd.ret && cwp_bwd == swp_q)
            |=> (trap_q == TRAP_FILL && $stable(cwp_q)));

    assert_trap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_q != TRAP_NONE && !cmd.ack) |=> ($stable(cwp_q) && $stable(swp_q)));

    assert_saved_only_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
        !cmd.ack |=> $stable(swp_q));

    assert_spill_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_q == TRAP_SPILL && cmd.ack)
            |=> (trap_q == TRAP_NONE && int'(swp_q) == ring_next(int'($past(swp_q)), NWIN)));

    assert_fill_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_q == TRAP_FILL && cmd.ack)
            |=> (trap_q == TRAP_NONE && int'(swp_q) == ring_prev(int'($past(swp_q)), NWIN)));

endmodule

// File: rtl/regwin_addr_map.sv
module regwin_addr_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NGLB = 8,
    parameter int NPAR = 6,
    parameter int NLOC = 4,
    parameter int NTMP = 6,
    parameter int AW   = 5,
    parameter int PW   = 3,
    parameter int IW   = 7
) (
    input  logic [AW-1:0] arch,
    input  logic [PW-1:0] cwp,
    output logic [IW-1:0] phys,
    output logic          hit
);

    localparam int STRIDE  = NPAR + NLOC;
    localparam int LOC_END = NGLB + NPAR + NLOC;
    localparam int ARCH_N  = LOC_END + NTMP;

    int a, w, idx;

    always_comb begin
        a   = int'(arch);
        w   = int'(cwp);
        idx = 0;
        hit = 1'b1;
        if (a == 0) begin
            hit = 1'b0;
        end else if (a < NGLB) begin
            idx = a;
        end else if (a < LOC_END) begin
            idx = NGLB + w * STRIDE + (a - NGLB);
        end else if (a < ARCH_N) begin
            idx = NGLB + ring_next(w, NWIN) * STRIDE + (a - LOC_END);
        end else begin
            hit = 1'b0;
        end
        phys = IW'(idx);
    end

endmodule

// File: rtl/regwin_storage.sv
module regwin_storage #(
    parameter int DEPTH = 88,
    parameter int DW    = 32,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    input  logic          rhit_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    input  logic          rhit_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = rhit_a ? mem[ridx_a] : '0;
    assign rdata_b = rhit_b ? mem[ridx_b] : '0;

    assert_write_commits_R11: assert property (@(posedge clk) disable iff (rst)
        (we && rhit_a && ridx_a == widx) |=> (rhit_a && ridx_a == $past(widx))
            |-> rdata_a == $past(wdata));

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NGLB = 8,
    parameter int NPAR = 6,
    parameter int NLOC = 4,
    parameter int NTMP = 6,
    parameter int DW   = 32,
    localparam int ARCH_N = NGLB + NPAR + NLOC + NTMP,
    localparam int AW     = $clog2(ARCH_N),
    localparam int PW     = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          trap_ack_i,
    output logic          spill_req_o,
    output logic          fill_req_o,
    output logic [PW-1:0] cur_win_o,
    output logic [PW-1:0] saved_win_o,
    input  logic [AW-1:0] rd_addr_a_i,
    output logic [DW-1:0] rd_data_a_o,
    input  logic [AW-1:0] rd_addr_b_i,
    output logic [DW-1:0] rd_data_b_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i
);

    localparam int PHYS_N = NGLB + NWIN * (NPAR + NLOC);
    localparam int IW     = $clog2(PHYS_N);
    localparam int NPORT  = 3;

    generate
        if (NTMP != NPAR) begin : g_bad_overlap
            $error("scratch and argument areas must be the same size");
        end
    endgenerate

    win_cmd_t      cmd;
    logic [PW-1:0] cwp, swp;
    trap_e         trap;

    assign cmd = '{call: call_i, ret: ret_i, ack: trap_ack_i};

    regwin_ptr_ctrl #(.NWIN(NWIN), .PW(PW)) u_ptr (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .cwp (cwp),
        .swp (swp),
        .trap(trap)
    );

    logic [AW-1:0] map_arch [NPORT];
    logic [IW-1:0] map_phys [NPORT];
    logic          map_hit  [NPORT];

    assign map_arch[0] = rd_addr_a_i;
    assign map_arch[1] = rd_addr_b_i;
    assign map_arch[2] = wr_addr_i;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_map
            regwin_addr_map #(
                .NWIN(NWIN), .NGLB(NGLB), .NPAR(NPAR), .NLOC(NLOC),
                .NTMP(NTMP), .AW(AW), .PW(PW), .IW(IW)
            ) u_map (
                .arch(map_arch[p]),
                .cwp (cwp),
                .phys(map_phys[p]),
                .hit (map_hit[p])
            );
        end
    endgenerate

    regwin_storage #(.DEPTH(PHYS_N), .DW(DW), .IW(IW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en_i && map_hit[2]),
        .widx   (map_phys[2]),
        .wdata  (wr_data_i),
        .ridx_a (map_phys[0]),
        .rhit_a (map_hit[0]),
        .rdata_a(rd_data_a_o),
        .ridx_b (map_phys[1]),
        .rhit_b (map_hit[1]),
        .rdata_b(rd_data_b_o)
    );

    assign spill_req_o = (trap == TRAP_SPILL);
    assign fill_req_o  = (trap == TRAP_FILL);
    assign cur_win_o   = cwp;
    assign saved_win_o = swp;

    assert_trap_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(spill_req_o && fill_req_o));

    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));

    assert_global_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr_b_i) < NGLB) |-> (int'(map_phys[1]) == int'(rd_addr_b_i)));

endmodule

// File: tb/test_regwin_file.sv
module test_regwin_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 0, ret_i = 0, trap_ack_i = 0;
    logic        spill_req_o, fill_req_o;
    logic [2:0]  cur_win_o, saved_win_o;
    logic [4:0]  rd_addr_a_i = 0, rd_addr_b_i = 0, wr_addr_i = 0;
    logic [31:0] rd_data_a_o, rd_data_b_o, wr_data_i = 0;
    logic        wr_en_i = 0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    regwin_file i_regwin_file (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .trap_ack_i(trap_ack_i), .spill_req_o(spill_req_o), .fill_req_o(fill_req_o),
        .cur_win_o(cur_win_o), .saved_win_o(saved_win_o),
        .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
        .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_a(string req, int addr, logic [31:0] exp);
        rd_addr_a_i = 5'(addr);
        #1;
        chk(req, $sformatf("read a r%0d", addr), rd_data_a_o, exp);
    endtask

    task automatic wr(int addr, logic [31:0] data);
        wr_en_i = 1; wr_addr_i = 5'(addr); wr_data_i = data;
        tick();
        wr_en_i = 0;
    endtask

    task automatic do_call();
        call_i = 1; tick(); call_i = 0;
    endtask

    task automatic do_ret();
        ret_i = 1; tick(); ret_i = 0;
    endtask

    task automatic do_ack();
        trap_ack_i = 1; tick(); trap_ack_i = 0;
    endtask

    task automatic ptrs(string req, int c, int s, bit sp, bit fl);
        chk(req, "current window", 32'(cur_win_o), 32'(c));
        chk(req, "saved window", 32'(saved_win_o), 32'(s));
        chk(req, "spill request", 32'(spill_req_o), 32'(sp));
        chk(req, "fill request", 32'(fill_req_o), 32'(fl));
    endtask

    task automatic t_reset();
        ptrs("R1", 0, 0, 0, 0);
        rd_a("R1", 5, 0);
        rd_a("R1", 20, 0);
    endtask

    task automatic t_zero_and_range();
        wr(3, 32'hA0A0_0003);
        wr(0, 32'hDEAD_0000);
        rd_a("R10", 0, 0);
        wr(25, 32'hDEAD_0025);
        rd_a("R10", 25, 0);
        rd_a("R10", 3, 32'hA0A0_0003);
    endtask

    task automatic t_overlap();
        wr(14, 32'h1111_0000);
        wr(18, 32'h7777_0000);
        do_call();
        ptrs("R2", 1, 0, 0, 0);
        rd_a("R8", 8, 32'h7777_0000);
        rd_a("R9", 14, 0);
        rd_addr_b_i = 5'd3; #1;
        chk("R7", "global via port b in window 1", rd_data_b_o, 32'hA0A0_0003);
        wr(14, 32'h1111_0001);
        wr(18, 32'h7777_0001);
        do_call();
        rd_a("R8", 8, 32'h7777_0001);
        rd_a("R9", 14, 0);
        do_ret();
        ptrs("R2", 1, 0, 0, 0);
        rd_a("R9", 14, 32'h1111_0001);
        rd_a("R8", 18, 32'h7777_0001);
    endtask

    task automatic t_write_timing();
        rd_addr_a_i = 5'd15;
        wr_en_i = 1; wr_addr_i = 5'd15; wr_data_i = 32'h5151_5151;
        #1;
        chk("R11", "read in write cycle", rd_data_a_o, 0);
        tick();
        wr_en_i = 0;
        chk("R11", "read after edge", rd_data_a_o, 32'h5151_5151);
    endtask

    task automatic t_overflow();
        for (int w = 2; w <= 7; w++) begin
            do_call();
            chk("R2", "call advance", 32'(cur_win_o), 32'(w));
        end
        wr(18, 32'h9999_0007);
        do_call();
        ptrs("R3", 7, 0, 1, 0);
        do_call();
        ptrs("R5", 7, 0, 1, 0);
        do_ack();
        ptrs("R5", 0, 1, 0, 0);
        rd_a("R8", 8, 32'h9999_0007);
        rd_a("R7", 3, 32'hA0A0_0003);
    endtask

    task automatic t_underflow();
        int exp_w = 0;
        for (int k = 0; k < 6; k++) begin
            do_ret();
            exp_w = (exp_w == 0) ? 7 : exp_w - 1;
            chk("R2", "return retreat", 32'(cur_win_o), 32'(exp_w));
        end
        do_ret();
        ptrs("R4", 2, 1, 0, 1);
        do_call();
        ptrs("R5", 2, 1, 0, 1);
        do_ack();
        ptrs("R5", 1, 0, 0, 0);
        rd_a("R9", 14, 32'h1111_0001);
    endtask

    task automatic t_simultaneous();
        call_i = 1; ret_i = 1;
        tick();
        call_i = 0; ret_i = 0;
        ptrs("R6", 2, 0, 0, 0);
        do_ack();
        ptrs("R6", 2, 0, 0, 0);
    endtask

    initial begin
        repeat (2) tick();
        rst = 0;
        t_reset();
        t_zero_and_range();
        t_overlap();
        t_write_timing();
        t_overflow();
        t_underflow();
        t_simultaneous();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule